// File: doc/BRIEF.md
# SPI Master/Slave Controller

This block is a byte-wide serial peripheral interface port that software drives through a small register window. It can run as bus master or as slave. As master it generates the serial clock from the system clock at one of four rates. It shifts one byte out and one byte in at the same time, most significant bit first. It drives one of several active-low slave-select lines. As slave it follows an external clock and select line, which pass through a two-stage synchronizer into the system clock domain.

Clock polarity and clock phase are set independently, which gives the four usual transfer formats. The block watches for two software and system errors. One is a data write that arrives while a byte is still moving. The other is a second master pulling the select input low while this block is master. On the second error the block gives up mastership and turns off its output drivers. Separate enable outputs control the external tri-state buffers on the clock, on the master data output and on the slave data output. One interrupt line reports transfer completion and mode faults.

Top module: `spi_port`

## Requirements
- R1: After reset the control, status, data and select registers read zero, `sck_oe`, `mosi_oe`, `miso_oe` and `irq` are low, and every `ss_n_o` line is high.
- R2: Register addresses are 0 control, 1 status, 2 data and 3 slave index. Control bit 0 enables the block and bit 1 selects master. In enabled master mode, a data write while idle sends that byte MSB first on `mosi_o` and takes in eight bits from `miso_i`. The byte taken in is then returned by a data read.
- R3: Control bit 2 (polarity) sets the idle level of `sck_o`. Control bit 3 (phase) picks the format. With phase 0, data is sampled on the leading clock edge and shifted on the trailing edge, and the first bit is valid before the first edge. With phase 1, data is shifted on the leading edge and sampled on the trailing edge.
- R4: Control bits 5:4 (rate 0..3) set the master half-period to 2, 4, 8 or 16 system clocks, so the fastest serial clock is one quarter of the system clock.
- R5: In slave mode, with `ss_n_i` low, the block exchanges a byte with an external master on `sck_i`, `mosi_i` and `miso_o`, in all four formats, using the byte last written to the data register.
- R6: `miso_oe` is high only in enabled slave mode while `ss_n_i` is low, and it is never high together with `sck_oe`.
- R7: A data write during a transfer sets status bit 1 (write collision). The written byte is discarded, and the bytes exchanged by the ongoing transfer are unchanged.
- R8: `ss_n_i` low in enabled master mode sets status bit 2 (mode fault), clears control bit 1, aborts the transfer and drops `sck_oe` and `mosi_oe`.
- R9: At the end of the eighth bit, status bit 0 (done) is set and status bit 3 (busy) is clear. When control bit 6 (interrupt enable) is set, `irq` is high while done or mode fault is set.
- R10: Flags are cleared only by a status read followed by a data access. A data read that no status read preceded leaves them set.
- R11: During a master transfer only `ss_n_o[k]` is low, where k is the value of the slave-index register. All lines are high otherwise.
- R12: `sck_oe` and `mosi_oe` are high in enabled master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on status/data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock generated as master |
| sck_oe | output | 1 | Tri-state enable for the clock pad |
| mosi_i | input | 1 | Serial data into the slave |
| mosi_o | output | 1 | Serial data out of the master |
| mosi_oe | output | 1 | Tri-state enable for the master data pad |
| miso_i | input | 1 | Serial data into the master |
| miso_o | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Tri-state enable for the slave data pad |
| ss_n_i | input | 1 | Slave select in, active low |
| ss_n_o | output | N_SS | Slave select lines driven as master, active low |

## Verification
The bench runs the block as master against a behavioural slave and as slave against a behavioural master, in every polarity and phase combination. It checks both bytes exchanged in each run. A design with the sample and shift edges swapped in one phase setting would return bytes shifted by one bit. The bench times the clock half-period at every rate, so a prescaler off by one cycle shows up as a wrong edge spacing. It writes data in the middle of a byte and checks that the transfer still delivers the original bytes; a design that let the write through would corrupt them. It also pulls the select input low during a master transfer and checks that the drivers are released and the master bit is cleared. Finally it reads data without a prior status read to catch a flag-clear rule that is too loose.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int PRE_W  = 5;
  localparam int RATE_W = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_SSEL = 2'd3;

  typedef struct packed {
    logic              ie;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
  } ctrl_t;

  // prescaler terminal count: half-period of (2 << rate) system clocks
  function automatic logic [PRE_W-1:0] half_limit(input logic [RATE_W-1:0] rate);
    return (PRE_W'(2) << rate) - PRE_W'(1);
  endfunction

  // shift a new bit in at the LSB end
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] r, input logic b);
    return {r[DATA_W-2:0], b};
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic busy, input logic modf,
                                                    input logic wcol, input logic done);
    return {{(DATA_W-4){1'b0}}, busy, modf, wcol, done};
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W      = 2,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= INIT;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
  import spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] lim;

  assign lim  = half_limit(rate);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else               cnt <= cnt + PRE_W'(1);
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              clr,
  input  logic              lead,
  input  logic              trail,
  input  logic              cpha,
  input  logic              sin,
  output logic              sout,
  output logic              last,
  output logic [DATA_W-1:0] rx_next
);
  logic [DATA_W-1:0] sreg;
  logic [BIT_W-1:0]  bcnt;
  logic              rbit;
  logic              obit;

  assign last    = trail && (bcnt == BIT_W'(DATA_W - 1));
  assign rx_next = shift_in(sreg, cpha ? sin : rbit);
  assign sout    = cpha ? obit : sreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      bcnt <= '0;
      rbit <= 1'b0;
      obit <= 1'b0;
    end else if (load) begin
      sreg <= ld_data;
      bcnt <= '0;
    end else if (clr) begin
      bcnt <= '0;
    end else begin
      if (lead) begin
        if (!cpha) rbit <= sin;
        else       obit <= sreg[DATA_W-1];
      end
      if (trail) begin
        sreg <= rx_next;
        bcnt <= last ? '0 : bcnt + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int N_SS = 4,
  localparam int SS_W = (N_SS > 1) ? $clog2(N_SS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i,
  output logic [N_SS-1:0]   ss_n_o
);
  ctrl_t             ctrl;
  logic [SS_W-1:0]   ssel;
  logic              busy_m, sck_lvl, armed;
  logic              done_f, wcol_f, modf_f;
  logic [DATA_W-1:0] rx_buf;

  // synchronized slave-side inputs
  logic sck_s, ss_s, sck_d;
  spi_sync #(.W(2), .STAGES(2), .INIT(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, ss_n_i}), .q({sck_s, ss_s})
  );

  // register strobes
  logic wr_ctrl, wr_data, wr_ssel, rd_stat, rd_data;
  assign wr_ctrl = reg_wr && reg_addr == ADDR_CTRL;
  assign wr_data = reg_wr && reg_addr == ADDR_DATA;
  assign wr_ssel = reg_wr && reg_addr == ADDR_SSEL;
  assign rd_stat = reg_rd && reg_addr == ADDR_STAT;
  assign rd_data = reg_rd && reg_addr == ADDR_DATA;

  // named internal events
  logic ctrl_master_w, ctrl_en_w, ctrl_cpol_w;
  logic slv_sel, busy_any, modf_ev, wcol_ev, start_m, load_ev, flag_clr;
  assign ctrl_master_w = ctrl.master;
  assign ctrl_en_w     = ctrl.en;
  assign ctrl_cpol_w   = ctrl.cpol;
  assign slv_sel  = ctrl.en && !ctrl.master && !ss_s;
  assign busy_any = ctrl.master ? busy_m : slv_sel;
  assign modf_ev  = ctrl.en && ctrl.master && !ss_s;
  assign wcol_ev  = wr_data && busy_any;
  assign load_ev  = wr_data && !busy_any;
  assign start_m  = load_ev && ctrl.en && ctrl.master && !modf_ev;
  assign flag_clr = armed && (rd_data || wr_data);

  // master clock generation
  logic tick;
  spi_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_m), .rate(ctrl.rate), .tick(tick)
  );

  // edge selection
  logic sck_rise, sck_fall, lead_m, trail_m, lead_s, trail_s;
  logic lead, trail, sin, shift_clr, shift_last, sout;
  logic [DATA_W-1:0] rx_next;
  assign lead_m   = tick && !sck_lvl;
  assign trail_m  = tick && sck_lvl;
  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;
  assign lead_s   = slv_sel && (ctrl.cpol ? sck_fall : sck_rise);
  assign trail_s  = slv_sel && (ctrl.cpol ? sck_rise : sck_fall);
  assign lead     = ctrl.master ? lead_m  : lead_s;
  assign trail    = ctrl.master ? trail_m : trail_s;
  assign sin      = ctrl.master ? miso_i  : mosi_i;
  assign shift_clr = (!ctrl.master && ss_s) || modf_ev;

  spi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .ld_data(reg_wdata), .clr(shift_clr),
    .lead(lead), .trail(trail), .cpha(ctrl.cpha), .sin(sin),
    .sout(sout), .last(shift_last), .rx_next(rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      ssel    <= '0;
      busy_m  <= 1'b0;
      sck_lvl <= 1'b0;
      sck_d   <= 1'b0;
      armed   <= 1'b0;
      done_f  <= 1'b0;
      wcol_f  <= 1'b0;
      modf_f  <= 1'b0;
      rx_buf  <= '0;
    end else begin
      sck_d <= sck_s;
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
      if (modf_ev) ctrl.master <= 1'b0;
      if (wr_ssel) ssel <= reg_wdata[SS_W-1:0];

      if (modf_ev)                       busy_m <= 1'b0;
      else if (start_m)                  busy_m <= 1'b1;
      else if (shift_last && ctrl.master) busy_m <= 1'b0;

      if (modf_ev)      sck_lvl <= 1'b0;
      else if (tick)    sck_lvl <= !sck_lvl;
      else if (!busy_m) sck_lvl <= 1'b0;

      if (shift_last) rx_buf <= rx_next;

      if (rd_stat)                 armed <= 1'b1;
      else if (rd_data || wr_data) armed <= 1'b0;

      done_f <= (done_f && !flag_clr) || shift_last;
      wcol_f <= (wcol_f && !flag_clr) || wcol_ev;
      modf_f <= (modf_f && !flag_clr) || modf_ev;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = DATA_W'(ctrl);
      ADDR_STAT: reg_rdata = pack_status(busy_any, modf_f, wcol_f, done_f);
      ADDR_DATA: reg_rdata = rx_buf;
      default:   reg_rdata = DATA_W'(ssel);
    endcase
  end

  assign irq     = ctrl.ie && (done_f || modf_f);
  assign sck_o   = ctrl.cpol ^ sck_lvl;
  assign sck_oe  = ctrl.en && ctrl.master;
  assign mosi_oe = sck_oe;
  assign mosi_o  = sout;
  assign miso_o  = sout;
  assign miso_oe = slv_sel;

  for (genvar k = 0; k < N_SS; k++) begin : g_ss
    assign ss_n_o[k] = !(busy_m && ssel == SS_W'(k));
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int N_SS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [1:0]      reg_addr,
  input logic            busy_any,
  input logic            busy_m,
  input logic            wcol_f,
  input logic            modf_f,
  input logic            done_f,
  input logic            shift_last,
  input logic            ctrl_master,
  input logic            ctrl_en,
  input logic            ctrl_cpol,
  input logic            sck_o,
  input logic            sck_oe,
  input logic            mosi_oe,
  input logic            miso_oe,
  input logic [N_SS-1:0] ss_n_o
);
  // R7
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && busy_any) |=> wcol_f);

  // R8
  modf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_f) |-> (!sck_oe && !mosi_oe && !ctrl_master));

  // R6
  drivers_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_oe && sck_oe));

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_m && ctrl_master && ctrl_en) |-> (sck_o == ctrl_cpol));

  // R11
  ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n_o));

  // R11
  ss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n_o != '1) |-> busy_m);

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_last |=> done_f);
endmodule

bind spi_port spi_port_chk #(.N_SS(N_SS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .busy_any(busy_any), .busy_m(busy_m), .wcol_f(wcol_f), .modf_f(modf_f),
  .done_f(done_f), .shift_last(shift_last), .ctrl_master(ctrl_master_w),
  .ctrl_en(ctrl_en_w), .ctrl_cpol(ctrl_cpol_w), .sck_o(sck_o), .sck_oe(sck_oe),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ss_n_o(ss_n_o)
);

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
  logic [3:0] ss_n_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_port #(.N_SS(4)) u_spi_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i), .ss_n_o(ss_n_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  function automatic logic [7:0] ctrl_word(input logic ie, input logic [1:0] rate,
      input logic cpha, input logic cpol, input logic master, input logic en);
    return {1'b0, ie, rate, cpha, cpol, master, en};
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), v);
      check("R1 register reset", v, 8'h00);
    end
    check("R1 sck_oe", sck_oe, 0);
    check("R1 miso_oe", miso_oe, 0);
    check("R1 ss_n_o", ss_n_o, 4'hF);
    check("R1 irq", irq, 0);
  endtask

  // master run against a behavioural slave
  task automatic t_master(input logic cpol, input logic cpha, input logic [1:0] rate,
                          input logic [7:0] tx, input logic [7:0] srv, input bit collide);
    logic [7:0] bs_tx, bs_rx, v;
    longint t0;
    bit lead;
    reg_write(2'd0, ctrl_word(1'b1, rate, cpha, cpol, 1'b1, 1'b1));
    reg_write(2'd3, 8'd2);
    check("R12 sck_oe master", sck_oe, 1);
    check("R12 mosi_oe master", mosi_oe, 1);
    check("R3 idle level", sck_o, cpol);
    bs_tx = srv; bs_rx = 0; t0 = 0;
    if (!cpha) miso_i = bs_tx[7];
    reg_write(2'd2, tx);
    check("R11 select line", ss_n_o, 4'b1011);
    for (int i = 0; i < 16; i++) begin
      @(sck_o);
      if (i == 0) t0 = longint'($time);
      if (i == 1) check("R4 half period", 32'(longint'($time) - t0), 32'((2 << rate) * 10));
      #1;
      lead = (sck_o != cpol);
      if (lead == !cpha) bs_rx = {bs_rx[6:0], mosi_o};
      else if (!cpha) begin bs_tx = bs_tx << 1; miso_i = bs_tx[7]; end
      else begin miso_i = bs_tx[7]; bs_tx = bs_tx << 1; end
      if (collide && i == 5) reg_write(2'd2, 8'hFF);
    end
    repeat (2) @(negedge clk);
    check("R9 irq on done", irq, 1);
    check("R11 select released", ss_n_o, 4'hF);
    check("R3 back to idle", sck_o, cpol);
    check(collide ? "R7 master sent original" : "R2 master sent", bs_rx, tx);
    reg_read(2'd2, v);
    check(collide ? "R7 received original" : "R2 master received", v, srv);
    reg_read(2'd1, v);
    check(collide ? "R7 collision flag" : "R10 flags kept after bare data read",
          v, {6'b0, collide, 1'b1});
    reg_read(2'd2, v);
    reg_read(2'd1, v);
    check("R10 flags cleared", v, 8'h00);
    check("R9 irq cleared", irq, 0);
  endtask

  // slave run driven by a behavioural master
  task automatic t_slave(input logic cpol, input logic cpha, input logic [7:0] stx,
                         input logic [7:0] mtx);
    logic [7:0] got, v;
    got = 0;
    sck_i = cpol; ss_n_i = 1;
    reg_write(2'd0, ctrl_word(1'b1, 2'd0, cpha, cpol, 1'b0, 1'b1));
    reg_write(2'd2, stx);
    repeat (4) @(negedge clk);
    check("R6 miso_oe deselected", miso_oe, 0);
    ss_n_i = 0;
    repeat (4) @(negedge clk);
    check("R6 miso_oe selected", miso_oe, 1);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = mtx[7 - i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = !cpol;
        repeat (8) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = !cpol;
        mosi_i = mtx[7 - i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    check("R9 slave irq", irq, 1);
    ss_n_i = 1;
    repeat (4) @(negedge clk);
    check("R6 miso_oe released", miso_oe, 0);
    check("R5 slave sent", got, stx);
    reg_read(2'd1, v);
    check("R5 slave done", v, 8'h01);
    reg_read(2'd2, v);
    check("R5 slave received", v, mtx);
  endtask

  task automatic t_modf;
    logic [7:0] v;
    ss_n_i = 1;
    reg_write(2'd0, ctrl_word(1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1));
    reg_write(2'd2, 8'h5A);
    repeat (20) @(negedge clk);
    ss_n_i = 0;
    repeat (4) @(negedge clk);
    check("R8 sck_oe dropped", sck_oe, 0);
    check("R8 mosi_oe dropped", mosi_oe, 0);
    check("R8 irq on fault", irq, 1);
    check("R8 select released", ss_n_o, 4'hF);
    ss_n_i = 1;
    repeat (4) @(negedge clk);
    reg_read(2'd0, v);
    check("R8 master bit cleared", v, 8'h71);
    reg_read(2'd1, v);
    check("R8 fault flag", v, 8'h04);
    reg_read(2'd2, v);
    reg_read(2'd1, v);
    check("R10 fault flag cleared", v, 8'h00);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_master(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b0);
    t_master(1'b1, 1'b0, 2'd1, 8'h81, 8'h7E, 1'b0);
    t_master(1'b0, 1'b1, 2'd2, 8'hC3, 8'h96, 1'b0);
    t_master(1'b1, 1'b1, 2'd3, 8'h01, 8'hF0, 1'b0);
    t_master(1'b0, 1'b0, 2'd2, 8'h6D, 8'hB2, 1'b1);
    t_slave(1'b0, 1'b0, 8'hC9, 8'h35);
    t_slave(1'b1, 1'b1, 8'h1E, 8'hE7);
    t_slave(1'b0, 1'b1, 8'h80, 8'h01);
    t_slave(1'b1, 1'b0, 8'h4B, 8'hD2);
    t_modf();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule